// File: doc/BRIEF.md
# Threshold-Driven Service Request FIFO

This block holds a 16-entry, byte-wide FIFO between a host register interface and a parallel peripheral port. It tells the host when to move a burst of data. A direction input selects the data path. In forward mode the host writes bytes in and the peripheral drains them. In reverse mode the peripheral fills the FIFO and the host reads the bytes out. The host reads the oldest byte on `head_data`, which always shows the front entry. The host also sees the fill level and the full and empty flags, so it can size each burst.

A 4-bit threshold sets the fill level at which a service request fires. In reverse mode the request fires once the stored count reaches sixteen minus the threshold. In forward mode it fires once the count has dropped to the threshold or below. A service state machine tracks the request through three named states:
- `SVC_ARMED`: the service bit is clear and the machine waits for the condition. Transition *arm→fire* is taken when the condition holds.
- `SVC_FIRE`: one cycle, in which the interrupt pulses and the service bit becomes set. Transition *fire→held* is always taken.
- `SVC_HELD`: the service bit stays set until the host pulses `svc_clr`. Transition *held→armed* is taken on that pulse.

The direction itself is a two-state register with states `PATH_FWD` and `PATH_REV`. A *path switch* happens whenever `dir_rev` differs from that register. On a path switch the FIFO is flushed, and every data strobe in that cycle is dropped. A host write to a full FIFO, or a host read from an empty one, changes nothing and sets a sticky error flag. That flag clears only on reset.

Top module: `pio_fifo_svc`

## Requirements
- R1: While reset is held, and right after it, `fill_level` is 0, `fifo_empty` is 1, `fifo_full` is 0, and `svc_bit`, `irq` and `err_sticky` are all 0.
- R2: The FIFO holds 16 bytes in arrival order. `head_data` shows the oldest byte. `fifo_full` rises after the sixteenth accepted push.
- R3: In forward mode a host write to a full FIFO is dropped. In reverse mode a host read from an empty FIFO is dropped. Either case sets `err_sticky` to 1, and the flag stays set. `fill_level` never goes past 16 and never wraps below 0.
- R4: In reverse mode (`dir_rev`=1), with the service bit clear, `irq` pulses one cycle after `fill_level` is at least 16 minus `thresh`. With threshold 0 this means only when full.
- R5: In forward mode (`dir_rev`=0), with the service bit clear, `irq` pulses one cycle after `fill_level` is at most `thresh`.
- R6: `irq` is high for exactly one cycle. `svc_bit` rises in that same cycle and stays 1 until `svc_clr` is pulsed. No further `irq` occurs while `svc_bit` is 1.
- R7: A `svc_clr` pulse while the service bit is set clears `svc_bit` on the next edge. If the condition still holds, `irq` pulses on the edge after that.
- R8: A change of `dir_rev` empties the FIFO on the next edge. Push and pop strobes in that cycle are dropped.
- R9: Strobes that belong to the other direction are dropped. In forward mode the path is `host_wr` in and `per_pop` out. In reverse mode the path is `per_push` in and `host_rd` out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_rev | input | 1 | 1 = peripheral-to-host, 0 = host-to-peripheral |
| thresh | input | 4 | Service threshold |
| svc_clr | input | 1 | Host pulse that clears the service bit |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe (pops the head byte) |
| per_push | input | 1 | Peripheral push strobe |
| per_wdata | input | 8 | Peripheral push byte |
| per_pop | input | 1 | Peripheral pop strobe |
| head_data | output | 8 | Oldest stored byte |
| fill_level | output | 5 | Number of stored bytes, 0 to 16 |
| fifo_full | output | 1 | FIFO holds 16 bytes |
| fifo_empty | output | 1 | FIFO holds no bytes |
| svc_bit | output | 1 | Service bit, set by hardware on a request |
| irq | output | 1 | One-cycle service request pulse |
| err_sticky | output | 1 | Sticky host overflow/underflow flag |

## Verification
The assertions assume that `svc_clr` and the data strobes are single-cycle pulses driven between clock edges. They also assume that `thresh` and `dir_rev` change only while no transfer is in flight. The bench changes `thresh` only under reset. It changes direction only at a negative edge, and it drives at most one strobe per cycle. Every check waits out the one-cycle lag between a fill-level change and the resulting `irq`. It also waits out the cycle the FIFO spends flushing after a direction change.

// File: rtl/pio_fifo_pkg.sv
package pio_fifo_pkg;

    typedef enum logic [1:0] {
        SVC_ARMED = 2'd0,
        SVC_FIRE  = 2'd1,
        SVC_HELD  = 2'd2
    } svc_state_t;

    typedef enum logic {
        PATH_FWD = 1'b0,
        PATH_REV = 1'b1
    } path_t;

endpackage

// File: rtl/pio_fifo_store.sv
module pio_fifo_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             push_ok;
    logic             pop_ok;

    assign full    = (count == DEPTH_C);
    assign empty   = (count == '0);
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R3: level stays within the storage
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= DEPTH_C);

    // R2: a lone accepted push grows the level by one
    p_push_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && !pop_ok) |=> (count == $past(count) + 1'b1));

    // R3: a push into a full FIFO without a pop leaves it full
    p_full_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full);

endmodule

// File: rtl/pio_svc_fsm.sv
module pio_svc_fsm
    import pio_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  path_t         path,
    input  logic [AW-1:0] thresh,
    input  logic [CW-1:0] count,
    input  logic          svc_clr,
    output logic          irq,
    output logic          svc_bit
);

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    svc_state_t state_q;
    svc_state_t state_d;
    logic       hit;
    logic [CW-1:0] rev_need;

    assign rev_need = DEPTH_C - CW'(thresh);

    always_comb begin
        unique case (path)
            PATH_REV: hit = (count >= rev_need);
            PATH_FWD: hit = (count <= CW'(thresh));
            default:  hit = 1'b0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SVC_ARMED: if (hit)     state_d = SVC_FIRE;
            SVC_FIRE:               state_d = SVC_HELD;
            SVC_HELD:  if (svc_clr) state_d = SVC_ARMED;
            default:                state_d = SVC_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SVC_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq     = 1'b0;
        svc_bit = 1'b0;
        unique case (state_q)
            SVC_ARMED: begin
                irq     = 1'b0;
                svc_bit = 1'b0;
            end
            SVC_FIRE: begin
                irq     = 1'b1;
                svc_bit = 1'b1;
            end
            SVC_HELD: begin
                irq     = 1'b0;
                svc_bit = 1'b1;
            end
            default: begin
                irq     = 1'b0;
                svc_bit = 1'b0;
            end
        endcase
    end

    // R6: the request is a single-cycle pulse
    p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R4: a request only follows a satisfied threshold condition
    p_irq_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(hit));

    // R6: the service bit is kept until the host clears it
    p_svc_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_bit && !svc_clr) |=> svc_bit);

    // R7: a clear from the held state drops the service bit
    p_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SVC_HELD && svc_clr) |=> !svc_bit);

endmodule

// File: rtl/pio_fifo_svc.sv
module pio_fifo_svc
    import pio_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_rev,
    input  logic [AW-1:0]    thresh,
    input  logic             svc_clr,
    input  logic             host_wr,
    input  logic [WIDTH-1:0] host_wdata,
    input  logic             host_rd,
    input  logic             per_push,
    input  logic [WIDTH-1:0] per_wdata,
    input  logic             per_pop,
    output logic [WIDTH-1:0] head_data,
    output logic [CW-1:0]    fill_level,
    output logic             fifo_full,
    output logic             fifo_empty,
    output logic             svc_bit,
    output logic             irq,
    output logic             err_sticky
);

    path_t            path_q;
    path_t            path_req;
    logic             flush;
    logic             push;
    logic             pop;
    logic [WIDTH-1:0] wdata;
    logic             host_err;

    assign path_req = dir_rev ? PATH_REV : PATH_FWD;
    assign flush    = (path_req != path_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            path_q <= PATH_REV;
        end else begin
            path_q <= path_req;
        end
    end

    always_comb begin
        push     = 1'b0;
        pop      = 1'b0;
        wdata    = host_wdata;
        host_err = 1'b0;
        unique case (path_q)
            PATH_FWD: begin
                push     = host_wr;
                pop      = per_pop;
                wdata    = host_wdata;
                host_err = host_wr && fifo_full;
            end
            PATH_REV: begin
                push     = per_push;
                pop      = host_rd;
                wdata    = per_wdata;
                host_err = host_rd && fifo_empty;
            end
            default: begin
                push     = 1'b0;
                pop      = 1'b0;
            end
        endcase
        if (flush) begin
            push     = 1'b0;
            pop      = 1'b0;
            host_err = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_sticky <= 1'b0;
        end else if (host_err) begin
            err_sticky <= 1'b1;
        end
    end

    pio_fifo_store #(
        .DEPTH (DEPTH),
        .WIDTH (WIDTH)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (push),
        .pop   (pop),
        .wdata (wdata),
        .head  (head_data),
        .count (fill_level),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    pio_svc_fsm #(
        .DEPTH (DEPTH)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .path    (path_q),
        .thresh  (thresh),
        .count   (fill_level),
        .svc_clr (svc_clr),
        .irq     (irq),
        .svc_bit (svc_bit)
    );

    // R3: the error flag never falls outside reset
    p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

    // R8: a direction change leaves the FIFO empty
    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fill_level == '0));

endmodule

// File: tb/pio_fifo_svc_tb.sv
module pio_fifo_svc_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dir_rev = 1'b1;
    logic [3:0] thresh = 4'd0;
    logic       svc_clr = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic       host_rd = 1'b0;
    logic       per_push = 1'b0;
    logic [7:0] per_wdata = 8'h00;
    logic       per_pop = 1'b0;
    logic [7:0] head_data;
    logic [4:0] fill_level;
    logic       fifo_full;
    logic       fifo_empty;
    logic       svc_bit;
    logic       irq;
    logic       err_sticky;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pio_fifo_svc u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .dir_rev    (dir_rev),
        .thresh     (thresh),
        .svc_clr    (svc_clr),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rd    (host_rd),
        .per_push   (per_push),
        .per_wdata  (per_wdata),
        .per_pop    (per_pop),
        .head_data  (head_data),
        .fill_level (fill_level),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .svc_bit    (svc_bit),
        .irq        (irq),
        .err_sticky (err_sticky)
    );

    // {dir_rev, thresh, fill count, expected request}
    localparam int NV = 17;
    localparam logic [10:0] VEC [NV] = '{
        {1'b1, 4'd12, 5'd3,  1'b0},
        {1'b1, 4'd12, 5'd4,  1'b1},
        {1'b1, 4'd12, 5'd16, 1'b1},
        {1'b1, 4'd0,  5'd15, 1'b0},
        {1'b1, 4'd0,  5'd16, 1'b1},
        {1'b1, 4'd15, 5'd1,  1'b1},
        {1'b1, 4'd15, 5'd0,  1'b0},
        {1'b1, 4'd8,  5'd7,  1'b0},
        {1'b1, 4'd8,  5'd8,  1'b1},
        {1'b0, 4'd12, 5'd12, 1'b1},
        {1'b0, 4'd12, 5'd13, 1'b0},
        {1'b0, 4'd0,  5'd0,  1'b1},
        {1'b0, 4'd0,  5'd1,  1'b0},
        {1'b0, 4'd15, 5'd15, 1'b1},
        {1'b0, 4'd15, 5'd16, 1'b0},
        {1'b0, 4'd4,  5'd4,  1'b1},
        {1'b0, 4'd4,  5'd5,  1'b0}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset(input bit dr, input logic [3:0] th);
        rst_n   = 1'b0;
        dir_rev = dr;
        thresh  = th;
        tick(); tick(); tick();
        rst_n = 1'b1;
        tick(); tick();
    endtask

    task automatic host_write(input logic [7:0] d);
        host_wr = 1'b1; host_wdata = d; tick(); host_wr = 1'b0;
    endtask

    task automatic host_read();
        host_rd = 1'b1; tick(); host_rd = 1'b0;
    endtask

    task automatic per_write(input logic [7:0] d);
        per_push = 1'b1; per_wdata = d; tick(); per_push = 1'b0;
    endtask

    task automatic per_read();
        per_pop = 1'b1; tick(); per_pop = 1'b0;
    endtask

    task automatic clear_svc();
        svc_clr = 1'b1; tick(); svc_clr = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        // R1: reset state, sampled while reset is held
        rst_n = 1'b0; dir_rev = 1'b1; thresh = 4'd3;
        tick(); tick();
        check(fill_level == 0, "R1 level", fill_level, 0);
        check(fifo_empty == 1'b1, "R1 empty", fifo_empty, 1);
        check(fifo_full == 1'b0, "R1 full", fifo_full, 0);
        check(svc_bit == 1'b0, "R1 svc", svc_bit, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);
        check(err_sticky == 1'b0, "R1 err", err_sticky, 0);

        // R4 / R5: threshold table
        for (int i = 0; i < NV; i++) begin
            logic       vd;
            logic [3:0] vt;
            logic [4:0] vn;
            logic       ve;
            {vd, vt, vn, ve} = VEC[i];
            do_reset(vd, vt);
            for (int k = 0; k < int'(vn); k++) begin
                if (vd) per_write(8'(k)); else host_write(8'(k));
            end
            tick(); tick();
            clear_svc();
            tick();
            if (vd) begin
                check(irq == ve, $sformatf("R4 irq vec %0d", i), irq, ve);
                check(svc_bit == ve, $sformatf("R4 svc vec %0d", i), svc_bit, ve);
            end else begin
                check(irq == ve, $sformatf("R5 irq vec %0d", i), irq, ve);
                check(svc_bit == ve, $sformatf("R5 svc vec %0d", i), svc_bit, ve);
            end
        end

        // R2 ordering and capacity, forward path
        do_reset(1'b0, 4'd0);
        for (int k = 0; k < 16; k++) host_write(8'hA0 + 8'(k));
        check(fill_level == 16, "R2 level full", fill_level, 16);
        check(fifo_full == 1'b1, "R2 full flag", fifo_full, 1);
        check(err_sticky == 1'b0, "R3 no err before overflow", err_sticky, 0);
        // R3: write into full FIFO
        host_write(8'hFF);
        check(fill_level == 16, "R3 overflow level", fill_level, 16);
        check(err_sticky == 1'b1, "R3 overflow err", err_sticky, 1);
        for (int k = 0; k < 16; k++) begin
            check(head_data == 8'hA0 + 8'(k), "R2 order", head_data, 8'hA0 + k);
            per_read();
        end
        check(fifo_empty == 1'b1, "R2 drained", fifo_empty, 1);
        check(err_sticky == 1'b1, "R3 err sticky", err_sticky, 1);

        // R3: read from empty FIFO in reverse
        do_reset(1'b1, 4'd0);
        host_read();
        check(fill_level == 0, "R3 underflow level", fill_level, 0);
        check(err_sticky == 1'b1, "R3 underflow err", err_sticky, 1);

        // R9: wrong-direction strobes ignored in reverse
        do_reset(1'b1, 4'd0);
        host_write(8'h11);
        check(fill_level == 0, "R9 host_wr ignored", fill_level, 0);
        per_write(8'h21);
        per_write(8'h22);
        per_read();
        check(fill_level == 2, "R9 per_pop ignored", fill_level, 2);
        check(head_data == 8'h21, "R9 head", head_data, 8'h21);
        host_read();
        check(fill_level == 1, "R9 host_rd pops", fill_level, 1);
        check(head_data == 8'h22, "R9 head after pop", head_data, 8'h22);

        // R8: direction change flushes, strobe in that cycle dropped
        dir_rev = 1'b0; per_push = 1'b1; per_wdata = 8'h33;
        tick();
        per_push = 1'b0;
        check(fill_level == 0, "R8 flushed", fill_level, 0);
        check(fifo_empty == 1'b1, "R8 empty", fifo_empty, 1);
        host_write(8'h44);
        check(fill_level == 1, "R8 forward path live", fill_level, 1);
        check(head_data == 8'h44, "R8 head", head_data, 8'h44);

        // R6 / R7: pulse width, hold, re-arm
        do_reset(1'b1, 4'd14);
        per_write(8'h01);
        per_write(8'h02);
        check(irq == 1'b0, "R6 irq lag", irq, 0);
        tick();
        check(irq == 1'b1, "R6 irq pulse", irq, 1);
        check(svc_bit == 1'b1, "R6 svc set", svc_bit, 1);
        tick();
        check(irq == 1'b0, "R6 irq one cycle", irq, 0);
        check(svc_bit == 1'b1, "R6 svc held", svc_bit, 1);
        per_write(8'h03);
        tick();
        check(irq == 1'b0, "R6 no repeat irq", irq, 0);
        clear_svc();
        check(svc_bit == 1'b0, "R7 svc cleared", svc_bit, 0);
        check(irq == 1'b0, "R7 irq not yet", irq, 0);
        tick();
        check(irq == 1'b1, "R7 rearm irq", irq, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule